// File: doc/BRIEF.md
# Code-Density Histogram Calibrator

This block calibrates the fine interpolator of a delay-line time-to-digital converter. The interpolator's taps are never equally spaced, so a raw fine code is not a linear measure of time. The calibrator is fed fine codes from hits whose start-to-stop interval is random and uncorrelated with the clock. With such hits, each code should be hit in proportion to the real width of its bin. The block counts hits per code until a programmed total is reached. From the counts it derives the width of each bin as a share of the full fine range. It then builds a table that gives every code the time at the centre of its bin.

Once the table is built, the same input port carries measurement codes. Each valid code is translated to a corrected fine time through the table, with one cycle of latency. This removes the fixed pattern that uneven bins would otherwise add to a histogram of real measurements. A clear command discards the counts and starts a new acquisition at any time.

The full range `T_RANGE` is given in output time units. The number of hits per acquisition is `2**LOG2_HITS`, so dividing by the total is a shift and no divider is needed.

Top module: `cdh_calibrator`

## Requirements
- R1: While reset is asserted and after it is released, `run_o` and `time_valid_o` are 0, the block is in acquisition, and every per-code counter is zero.
- R2: In acquisition, each hit with `hit_valid_i`=1 adds one to the counter of code `hit_code_i`. Counters saturate at `2**CNT_W-1`.
- R3: Acquisition ends on exactly the `2**LOG2_HITS`-th accepted hit. Hits to a saturated counter still count towards this total, and fewer hits never end acquisition.
- R4: After the final hit, the table is built in exactly `2**CODE_W` cycles. `run_o` rises at the end of that time and stays high until a clear.
- R5: Let S be the sum of the counts of all codes below k, and c the count of code k. For c>0, the table entry of code k is floor((2*S + c) * T_RANGE / 2**(LOG2_HITS+1)): the bin start plus half the bin width.
- R6: A code with a count of zero has zero width. Its entry equals the entry of code k-1, and it is 0 for code 0.
- R7: In the run phase, a hit with `hit_valid_i`=1 sets `time_valid_o`=1 one cycle later, with `time_o` equal to the table entry of that code. `time_valid_o` is 0 in every other cycle. Lookups change neither the counts nor the table.
- R8: `clear_i` in any phase zeroes all counters and the hit total and returns the block to acquisition. `run_o` is 0 in the next cycle. A hit presented in the same cycle as `clear_i` is not counted.
- R9: Hits presented while the table is being built are ignored and do not change the table.
- R10: `time_valid_o` never rises in response to hits presented in acquisition or in the build phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clear_i | input | 1 | Zero the histogram and restart acquisition |
| hit_valid_i | input | 1 | A fine code is present on `hit_code_i` |
| hit_code_i | input | CODE_W | Raw fine code of the interpolator |
| run_o | output | 1 | Table is built and lookups are served |
| time_valid_o | output | 1 | `time_o` carries a new corrected time |
| time_o | output | $clog2(T_RANGE+1) | Corrected fine time of the looked-up code |

## Verification
The bench builds the block with CODE_W=4, CNT_W=5, LOG2_HITS=6 and T_RANGE=1000: 16 bins, 64 hits per acquisition and counters that saturate at 31. With these values every table entry is read back after every acquisition. The expected times are recomputed from a count model kept in the bench. Several acquisitions fit in a short run: a uniform load, alternating empty bins, a single saturated bin and a pseudo-random stream with gaps. Saturation, zero-width bins, the exact end of acquisition and the build length can all be reached.

// File: rtl/cdh_pkg.sv
`timescale 1ns/1ps
package cdh_pkg;
  typedef enum logic [1:0] {
    PH_ACQ   = 2'd0,
    PH_BUILD = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/cdh_bin_cnt.sv
`timescale 1ns/1ps
module cdh_bin_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // Saturated counter never wraps (R2)
  assert_sat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));

  // Counter moves by at most one per cycle (R2)
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE));

  // Clear empties the bin (R8)
  assert_bin_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/cdh_histogram.sv
`timescale 1ns/1ps
module cdh_histogram #(
  parameter int CODE_W    = 8,
  parameter int CNT_W     = 12,
  parameter int LOG2_HITS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              acq_en_i,
  input  logic              hit_valid_i,
  input  logic [CODE_W-1:0] hit_code_i,
  input  logic [CODE_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              last_hit_o
);
  localparam int NBINS = 1 << CODE_W;
  localparam logic [LOG2_HITS-1:0] TOT_LAST = '1;
  localparam logic [LOG2_HITS-1:0] TOT_ONE  = LOG2_HITS'(1);

  logic                 accept;
  logic [CNT_W-1:0]     bin_cnt [NBINS];
  logic [LOG2_HITS-1:0] tot_q, tot_d;

  assign accept = acq_en_i && hit_valid_i && !clear_i;

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    logic inc;
    assign inc = accept && (hit_code_i == CODE_W'(b));
    cdh_bin_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(clear_i),
      .inc_i  (inc),
      .cnt_o  (bin_cnt[b])
    );
  end

  assign rd_cnt_o = bin_cnt[rd_idx_i];

  always_comb begin
    tot_d = tot_q;
    if (clear_i) begin
      tot_d = '0;
    end else if (accept) begin
      tot_d = tot_q + TOT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0;
    end else begin
      tot_q <= tot_d;
    end
  end

  assign last_hit_o = accept && (tot_q == TOT_LAST);

  // Hit total restarts on clear (R8)
  assert_total_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (tot_q == '0));

  // The closing hit wraps the total to zero (R3)
  assert_last_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit_o |=> (tot_q == '0));
endmodule

// File: rtl/cdh_builder.sv
`timescale 1ns/1ps
module cdh_builder #(
  parameter int CODE_W    = 8,
  parameter int CNT_W     = 12,
  parameter int LOG2_HITS = 14,
  parameter int T_RANGE   = 4000,
  parameter int TIME_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CODE_W-1:0] idx_o,
  output logic              wr_en_o,
  output logic [TIME_W-1:0] wr_data_o,
  output logic              done_o
);
  localparam int SUM_W  = LOG2_HITS + 1;
  localparam int ACC_W  = LOG2_HITS + 2;
  localparam int PROD_W = ACC_W + TIME_W;
  localparam int SHIFT  = LOG2_HITS + 1;
  localparam logic [CODE_W-1:0] IDX_LAST = '1;
  localparam logic [CODE_W-1:0] IDX_ONE  = CODE_W'(1);
  localparam logic [TIME_W-1:0] T_VEC    = TIME_W'(T_RANGE);

  logic [CODE_W-1:0] idx_q, idx_d;
  logic [SUM_W-1:0]  pref_q, pref_d;
  logic [TIME_W-1:0] prev_q, prev_d;
  logic [ACC_W-1:0]  acc;
  logic [PROD_W-1:0] prod;
  logic [TIME_W-1:0] entry;

  // twice the bin start plus the bin width, in hit units
  assign acc   = {pref_q, 1'b0} + ACC_W'(cnt_i);
  assign prod  = PROD_W'(acc) * PROD_W'(T_VEC);
  assign entry = (cnt_i == '0) ? prev_q : TIME_W'(prod >> SHIFT);

  always_comb begin
    idx_d  = '0;
    pref_d = '0;
    prev_d = '0;
    if (active_i) begin
      idx_d  = idx_q + IDX_ONE;
      pref_d = pref_q + SUM_W'(cnt_i);
      prev_d = entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pref_q <= '0;
      prev_q <= '0;
    end else begin
      idx_q  <= idx_d;
      pref_q <= pref_d;
      prev_q <= prev_d;
    end
  end

  assign idx_o     = idx_q;
  assign wr_en_o   = active_i;
  assign wr_data_o = entry;
  assign done_o    = active_i && (idx_q == IDX_LAST);

  // Corrected times never decrease with the code (R5, R6)
  assert_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (wr_data_o >= prev_q));

  // No entry lies beyond the full range (R5)
  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (wr_data_o <= T_VEC));

  // One table entry per cycle while building (R4)
  assert_walk_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !done_o) |=> (idx_q == $past(idx_q) + IDX_ONE || idx_q == '0));
endmodule

// File: rtl/cdh_lookup.sv
`timescale 1ns/1ps
module cdh_lookup #(
  parameter int CODE_W = 8,
  parameter int TIME_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_idx_i,
  input  logic [TIME_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [CODE_W-1:0] rd_code_i,
  output logic              valid_o,
  output logic [TIME_W-1:0] time_o
);
  localparam int NBINS = 1 << CODE_W;

  logic [TIME_W-1:0] tbl_q [NBINS];
  logic              valid_q, valid_d;
  logic [TIME_W-1:0] time_q, time_d;

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tbl_q[wr_idx_i] <= wr_data_i;
    end
  end

  always_comb begin
    valid_d = rd_en_i;
    time_d  = time_q;
    if (rd_en_i) begin
      time_d = tbl_q[rd_code_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      time_q  <= '0;
    end else begin
      valid_q <= valid_d;
      time_q  <= time_d;
    end
  end

  assign valid_o = valid_q;
  assign time_o  = time_q;

  // A lookup answers one cycle later (R7)
  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> valid_o);

  // No answer without a lookup, and the output holds (R7, R10)
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (!valid_o && $stable(time_o)));
endmodule

// File: rtl/cdh_calibrator.sv
`timescale 1ns/1ps
module cdh_calibrator
  import cdh_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int CNT_W     = 12,
  parameter int LOG2_HITS = 14,
  parameter int T_RANGE   = 4000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear_i,
  input  logic                           hit_valid_i,
  input  logic [CODE_W-1:0]              hit_code_i,
  output logic                           run_o,
  output logic                           time_valid_o,
  output logic [$clog2(T_RANGE+1)-1:0]   time_o
);
  localparam int TIME_W = $clog2(T_RANGE + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  phase_e            phase_q, phase_d;
  logic              last_hit;
  logic              build_done;
  logic              build_act;
  logic              lookup_en;
  logic [CODE_W-1:0] build_idx;
  logic [CNT_W-1:0]  build_cnt;
  logic              tbl_wr;
  logic [TIME_W-1:0] tbl_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    phase_d = phase_q;
    if (clear_i) begin
      phase_d = PH_ACQ;
    end else begin
      case (phase_q)
        PH_ACQ:   if (last_hit)   phase_d = PH_BUILD;
        PH_BUILD: if (build_done) phase_d = PH_RUN;
        PH_RUN:   phase_d = PH_RUN;
        default:  phase_d = PH_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_ACQ;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign build_act = (phase_q == PH_BUILD) && !clear_i;
  assign lookup_en = (phase_q == PH_RUN) && hit_valid_i && !clear_i;
  assign run_o     = (phase_q == PH_RUN);

  cdh_histogram #(
    .CODE_W   (CODE_W),
    .CNT_W    (CNT_W),
    .LOG2_HITS(LOG2_HITS)
  ) u_hist (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (clear_i),
    .acq_en_i   (phase_q == PH_ACQ),
    .hit_valid_i(hit_valid_i),
    .hit_code_i (hit_code_i),
    .rd_idx_i   (build_idx),
    .rd_cnt_o   (build_cnt),
    .last_hit_o (last_hit)
  );

  cdh_builder #(
    .CODE_W   (CODE_W),
    .CNT_W    (CNT_W),
    .LOG2_HITS(LOG2_HITS),
    .T_RANGE  (T_RANGE),
    .TIME_W   (TIME_W)
  ) u_build (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .active_i (build_act),
    .cnt_i    (build_cnt),
    .idx_o    (build_idx),
    .wr_en_o  (tbl_wr),
    .wr_data_o(tbl_data),
    .done_o   (build_done)
  );

  cdh_lookup #(
    .CODE_W(CODE_W),
    .TIME_W(TIME_W)
  ) u_lut (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en_i  (tbl_wr),
    .wr_idx_i (build_idx),
    .wr_data_i(tbl_data),
    .rd_en_i  (lookup_en),
    .rd_code_i(hit_code_i),
    .valid_o  (time_valid_o),
    .time_o   (time_o)
  );

  // Run phase persists until a clear (R4)
  assert_run_sticky_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run_o && !clear_i) |=> run_o);

  // Clear returns to acquisition (R8)
  assert_clear_to_acq_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    clear_i |=> (!run_o && phase_q == PH_ACQ));

  // Corrected times appear only for lookups made in the run phase (R10)
  assert_time_only_in_run_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    time_valid_o |-> $past(run_o));
endmodule

// File: tb/cdh_calibrator_tb.sv
`timescale 1ns/1ps
module cdh_calibrator_tb;
  localparam int CODE_W    = 4;
  localparam int CNT_W     = 5;
  localparam int LOG2_HITS = 6;
  localparam int T_RANGE   = 1000;
  localparam int NBINS     = 1 << CODE_W;
  localparam int NHITS     = 1 << LOG2_HITS;
  localparam int CMAX      = (1 << CNT_W) - 1;
  localparam int TIME_W    = $clog2(T_RANGE + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              clear_i;
  logic              hit_valid_i;
  logic [CODE_W-1:0] hit_code_i;
  logic              run_o;
  logic              time_valid_o;
  logic [TIME_W-1:0] time_o;

  int nchk = 0;
  int nerr = 0;
  int mcnt [NBINS];

  always #2 clk = ~clk;

  cdh_calibrator #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .LOG2_HITS(LOG2_HITS), .T_RANGE(T_RANGE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .hit_valid_i(hit_valid_i),
    .hit_code_i(hit_code_i), .run_o(run_o), .time_valid_o(time_valid_o), .time_o(time_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_time(input int k);
    int s = 0;
    int r = 0;
    for (int j = 0; j <= k; j++) begin
      if (mcnt[j] != 0) r = ((2 * s + mcnt[j]) * T_RANGE) >> (LOG2_HITS + 1);
      s += mcnt[j];
    end
    return r;
  endfunction

  task automatic model_clear();
    for (int j = 0; j < NBINS; j++) mcnt[j] = 0;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic send_hit(input int code);
    hit_valid_i = 1'b1;
    hit_code_i  = CODE_W'(code);
    @(negedge clk);
    hit_valid_i = 1'b0;
    if (mcnt[code] < CMAX) mcnt[code]++;
    check(time_valid_o == 1'b0, "R10 no output in acquisition", time_valid_o, 0);
  endtask

  task automatic do_clear(input bit with_hit);
    clear_i     = 1'b1;
    hit_valid_i = with_hit;
    hit_code_i  = CODE_W'(7);
    @(negedge clk);
    clear_i     = 1'b0;
    hit_valid_i = 1'b0;
    model_clear();
    check(run_o == 1'b0, "R8 run_o low after clear", run_o, 0);
  endtask

  task automatic wait_run(input bit poke);
    int n = 0;
    if (poke) begin
      hit_valid_i = 1'b1;
      hit_code_i  = CODE_W'(1);
    end
    while (!run_o && n < 100) begin
      @(negedge clk);
      n++;
      if (!run_o) check(time_valid_o == 1'b0, "R10 no output while building", time_valid_o, 0);
    end
    hit_valid_i = 1'b0;
    check(n == NBINS, "R4 build length", n, NBINS);
  endtask

  task automatic verify_table(input string tag);
    for (int k = 0; k < NBINS; k++) begin
      hit_valid_i = 1'b1;
      hit_code_i  = CODE_W'(k);
      @(negedge clk);
      check(time_valid_o == 1'b1, {"R7 lookup valid ", tag}, time_valid_o, 1);
      check(int'(time_o) == exp_time(k), {"R5 R6 corrected time ", tag}, time_o, exp_time(k));
    end
    hit_valid_i = 1'b0;
    @(negedge clk);
    check(time_valid_o == 1'b0, {"R7 valid drops ", tag}, time_valid_o, 0);
    check(run_o == 1'b1, {"R4 run holds ", tag}, run_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; clear_i = 1'b0; hit_valid_i = 1'b0; hit_code_i = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check(run_o == 1'b0 && time_valid_o == 1'b0, "R1 outputs in reset", {run_o, time_valid_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(run_o == 1'b0 && time_valid_o == 1'b0, "R1 outputs after reset", {run_o, time_valid_o}, 0);

    // partial acquisition, then clear with a colliding hit (R8)
    for (int i = 0; i < 20; i++) send_hit(5);
    do_clear(1'b1);

    // uniform load; 63 hits must not end acquisition (R3); fresh counters (R1)
    for (int i = 0; i < NHITS - 1; i++) send_hit(i % NBINS);
    repeat (3) @(negedge clk);
    check(run_o == 1'b0, "R3 one hit short", run_o, 0);
    send_hit(NBINS - 1);
    wait_run(1'b0);
    verify_table("uniform R1 R8");
    verify_table("repeat R7");

    // clear from run (R8); alternating empty bins (R6); hits while building (R9)
    do_clear(1'b0);
    for (int i = 0; i < NHITS; i++) send_hit((i % (NBINS / 2)) * 2);
    wait_run(1'b1);
    verify_table("empty bins R6 R9");

    // one bin saturates, hits to it still count (R2, R3)
    do_clear(1'b0);
    for (int i = 0; i < 40; i++) send_hit(3);
    for (int c = 4; c < NBINS; c++) begin
      send_hit(c);
      send_hit(c);
    end
    wait_run(1'b0);
    verify_table("saturated R2 R3");

    // pseudo-random codes with idle gaps (R2, R5)
    do_clear(1'b0);
    lfsr = 8'hA5;
    for (int i = 0; i < NHITS; i++) begin
      send_hit(int'(lfsr[3:0]));
      if (lfsr[7] && i != NHITS - 1) @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    wait_run(1'b0);
    verify_table("random R2 R5");

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule